// File: doc/BRIEF.md
# Inbound Write Ordering Handshake

This block sits where a host-to-PCI bridge receives inbound requests on its legacy-compatible bus. It classifies each request and forwards the supported ones to the system bus, tagged with a fixed agent ID. Inbound I/O requests and memory requests that fall inside the peer PCI window are not forwarded. They are answered with a master-abort response, and each is counted in a saturating counter kept for its own error type.

For ordering, the block drives an active-low write-snoop-complete line (`wsc_n`). Low means no legacy write is outstanding. When the handshake is active, the block accepts one write from the legacy south-bridge master and raises the line at once. Any further write from that master gets a retry until the completion tagged for the tracked write comes back. This lets the legacy master hold back an interrupt until its earlier posted write has been seen.

The handshake runs only when the internal arbiter is selected and the enable bit is set. A change to either setting made while a write is being tracked takes effect only after that write's completion returns.

Top module: `iwo_handshake`

## Requirements
- R1: After a synchronous reset, `wsc_n`, `fwd_valid`, `rsp_valid` and `err_orphan_cpl` are 0, and both error counters are 0.
- R2: A request is answered one clock after it is sampled: `rsp_valid` is 1 and `rsp_code` is 00 accept, 01 retry or 10 master-abort. Every forwarded request (`fwd_valid`=1) carries `fwd_agent` = 4'b1001 together with the request's address and write flag.
- R3: With the handshake active (`cfg_hs_en`=1, `cfg_int_arb`=1) and `wsc_n` low, a supported south-bridge write (`req_sb`=1, `req_kind`=01) is accepted and forwarded with `fwd_tracked`=1, and `wsc_n` is high from the next cycle.
- R4: `wsc_n` stays high until a cycle with `cpl_valid`=1 and `cpl_sb`=1. It is low from the following cycle. Completions with `cpl_sb`=0 do not release it.
- R5: While `wsc_n` is high, a supported south-bridge write gets a retry and is not forwarded. This holds also when the releasing completion arrives in the same cycle.
- R6: With `cfg_int_arb`=0 (external arbiter), `wsc_n` stays low and south-bridge writes are accepted and forwarded.
- R7: With `cfg_hs_en`=0, `wsc_n` stays low and south-bridge writes are accepted and forwarded.
- R8: A request with `req_kind` 10 (I/O read) or 11 (I/O write) gets a master-abort, is not forwarded, and increments `err_io_cnt`.
- R9: A memory request whose address lies in [`PEER_BASE`, `PEER_LIMIT`) gets a master-abort, is not forwarded, and increments `err_p2p_cnt`.
- R10: Reads (`req_kind` 00) from any master, and writes with `req_sb`=0, are forwarded with `fwd_tracked`=0 and leave `wsc_n` unchanged, also while a write is tracked.
- R11: A completion with `cpl_sb`=1 that arrives while `wsc_n` is low leaves `wsc_n` low and sets `err_orphan_cpl`. The flag stays set until reset.
- R12: A change of `cfg_hs_en` or `cfg_int_arb` while `wsc_n` is high does not lower it and does not stop retries. The new setting applies after the completion.
- R13: Both error counters saturate at their all-ones value.
- R14: An unsupported south-bridge request gets a master-abort rather than a retry, even while `wsc_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hs_en | input | 1 | Handshake enable bit |
| cfg_int_arb | input | 1 | 1 selects internal arbiter mode |
| req_valid | input | 1 | Inbound request present this cycle |
| req_kind | input | 2 | 00 mem read, 01 mem write, 10 I/O read, 11 I/O write |
| req_addr | input | AW | Request address |
| req_sb | input | 1 | Request comes from the south-bridge master |
| cpl_valid | input | 1 | System-bus completion present |
| cpl_sb | input | 1 | Completion belongs to the tracked south-bridge write |
| fwd_valid | output | 1 | Forwarded request to the system bus |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_addr | output | AW | Forwarded address |
| fwd_agent | output | 4 | Agent ID of the forwarded request |
| fwd_tracked | output | 1 | Forwarded write is the tracked south-bridge write |
| rsp_valid | output | 1 | Response to the inbound master |
| rsp_code | output | 2 | 00 accept, 01 retry, 10 master-abort |
| wsc_n | output | 1 | Write-snoop-complete, active low |
| err_orphan_cpl | output | 1 | Sticky: tracked completion with nothing pending |
| err_io_cnt | output | CNT_W | Saturating count of I/O requests |
| err_p2p_cnt | output | CNT_W | Saturating count of peer-window requests |

## Verification
The hardest case is a change of configuration while a tracked write is outstanding. Here `wsc_n` must ignore the new setting, and retries must go on until the completion. The stimulus first accepts a south-bridge write with the handshake active. It then clears the enable bit and sends another south-bridge write, which must still be retried. After the completion it sends a third write, which must be accepted with `wsc_n` staying low. The cycle where a retried write meets its releasing completion, and the point where the counters saturate after 300 I/O requests, are also reached directly.

// File: rtl/iwo_pkg.sv
package iwo_pkg;

    typedef enum logic [1:0] {
        RK_MEM_RD = 2'b00,
        RK_MEM_WR = 2'b01,
        RK_IO_RD  = 2'b10,
        RK_IO_WR  = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        RS_ACCEPT = 2'b00,
        RS_RETRY  = 2'b01,
        RS_MABORT = 2'b10
    } rsp_code_e;

    localparam int ERR_IO   = 0;
    localparam int ERR_P2P  = 1;
    localparam int NUM_ERR  = 2;

    typedef struct packed {
        logic is_write;
        logic hit_io;
        logic hit_p2p;
    } req_class_t;

    function automatic logic kind_is_io(req_kind_e k);
        return (k == RK_IO_RD) || (k == RK_IO_WR);
    endfunction

    function automatic logic kind_is_write(req_kind_e k);
        return (k == RK_MEM_WR) || (k == RK_IO_WR);
    endfunction

endpackage

// File: rtl/iwo_decode.sv
module iwo_decode
    import iwo_pkg::*;
#(
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  PEER_BASE  = 32'hC000_0000,
    parameter logic [AW-1:0]  PEER_LIMIT = 32'hE000_0000
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    output req_class_t    cls
);
    req_kind_e k;
    logic      in_win;

    always_comb begin
        k           = req_kind_e'(kind);
        in_win      = (addr >= PEER_BASE) && (addr < PEER_LIMIT);
        cls.is_write = kind_is_write(k);
        cls.hit_io   = kind_is_io(k);
        cls.hit_p2p  = !kind_is_io(k) && in_win;
    end
endmodule

// File: rtl/iwo_order_track.sv
module iwo_order_track (
    input  logic clk,
    input  logic rst,
    input  logic track_set,
    input  logic cpl_hit,
    output logic pending,
    output logic orphan
);
    logic pend_q;
    logic orphan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            orphan_q <= 1'b0;
        end else begin
            if (track_set)
                pend_q <= 1'b1;
            else if (cpl_hit)
                pend_q <= 1'b0;
            if (cpl_hit && !pend_q)
                orphan_q <= 1'b1;
        end
    end

    assign pending = pend_q;
    assign orphan  = orphan_q;
endmodule

// File: rtl/iwo_err_count.sv
module iwo_err_count #(
    parameter int CNT_W = 8,
    parameter int NUM   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM-1:0]     inc,
    output logic [NUM*CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < NUM; i++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst)
                c_q <= '0;
            else if (inc[i] && (c_q != CNT_MAX))
                c_q <= c_q + 1'b1;
        end
        assign cnt[i*CNT_W +: CNT_W] = c_q;
    end
endmodule

// File: rtl/iwo_handshake.sv
module iwo_handshake
    import iwo_pkg::*;
#(
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  PEER_BASE  = 32'hC000_0000,
    parameter logic [AW-1:0]  PEER_LIMIT = 32'hE000_0000,
    parameter logic [3:0]     AGENT_ID   = 4'b1001,
    parameter int             CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_hs_en,
    input  logic             cfg_int_arb,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_sb,
    input  logic             cpl_valid,
    input  logic             cpl_sb,
    output logic             fwd_valid,
    output logic             fwd_write,
    output logic [AW-1:0]    fwd_addr,
    output logic [3:0]       fwd_agent,
    output logic             fwd_tracked,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic             wsc_n,
    output logic             err_orphan_cpl,
    output logic [CNT_W-1:0] err_io_cnt,
    output logic [CNT_W-1:0] err_p2p_cnt
);
    req_class_t         cls;
    logic               pending;
    logic               unsupported;
    logic               sb_wr;
    logic               retry;
    logic               go;
    logic               hs_on;
    logic               track_set;
    logic               cpl_hit;
    logic [NUM_ERR-1:0] err_inc;
    logic [NUM_ERR*CNT_W-1:0] err_cnt;

    logic               fwd_valid_q;
    logic               fwd_write_q;
    logic [AW-1:0]      fwd_addr_q;
    logic               fwd_tracked_q;
    logic               rsp_valid_q;
    rsp_code_e          rsp_code_q;

    iwo_decode #(
        .AW        (AW),
        .PEER_BASE (PEER_BASE),
        .PEER_LIMIT(PEER_LIMIT)
    ) u_decode (
        .kind(req_kind),
        .addr(req_addr),
        .cls (cls)
    );

    always_comb begin
        unsupported = cls.hit_io | cls.hit_p2p;
        sb_wr       = req_valid && req_sb && cls.is_write && !unsupported;
        retry       = sb_wr && pending;
        go          = req_valid && !unsupported && !retry;
        hs_on       = cfg_hs_en && cfg_int_arb;
        track_set   = sb_wr && !pending && hs_on;
        cpl_hit     = cpl_valid && cpl_sb;
        err_inc     = '0;
        err_inc[ERR_IO]  = req_valid && cls.hit_io;
        err_inc[ERR_P2P] = req_valid && cls.hit_p2p;
    end

    iwo_order_track u_track (
        .clk      (clk),
        .rst      (rst),
        .track_set(track_set),
        .cpl_hit  (cpl_hit),
        .pending  (pending),
        .orphan   (err_orphan_cpl)
    );

    iwo_err_count #(
        .CNT_W(CNT_W),
        .NUM  (NUM_ERR)
    ) u_err (
        .clk(clk),
        .rst(rst),
        .inc(err_inc),
        .cnt(err_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid_q   <= 1'b0;
            fwd_write_q   <= 1'b0;
            fwd_addr_q    <= '0;
            fwd_tracked_q <= 1'b0;
            rsp_valid_q   <= 1'b0;
            rsp_code_q    <= RS_ACCEPT;
        end else begin
            fwd_valid_q   <= go;
            fwd_write_q   <= go && cls.is_write;
            fwd_tracked_q <= track_set;
            if (go)
                fwd_addr_q <= req_addr;
            rsp_valid_q   <= req_valid;
            if (unsupported)
                rsp_code_q <= RS_MABORT;
            else if (retry)
                rsp_code_q <= RS_RETRY;
            else
                rsp_code_q <= RS_ACCEPT;
        end
    end

    assign fwd_valid   = fwd_valid_q;
    assign fwd_write   = fwd_write_q;
    assign fwd_addr    = fwd_addr_q;
    assign fwd_agent   = fwd_valid_q ? AGENT_ID : 4'b0000;
    assign fwd_tracked = fwd_tracked_q;
    assign rsp_valid   = rsp_valid_q;
    assign rsp_code    = rsp_code_q;
    assign wsc_n       = pending;
    assign err_io_cnt  = err_cnt[ERR_IO*CNT_W +: CNT_W];
    assign err_p2p_cnt = err_cnt[ERR_P2P*CNT_W +: CNT_W];
endmodule

// File: rtl/iwo_handshake_chk.sv
module iwo_handshake_chk #(
    parameter logic [3:0] AGENT_ID = 4'b1001
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_hs_en,
    input logic       cfg_int_arb,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       req_sb,
    input logic       cpl_valid,
    input logic       cpl_sb,
    input logic       fwd_valid,
    input logic [3:0] fwd_agent,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       wsc_n,
    input logic       err_orphan_cpl
);
    AST_AGENT_ID: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_agent == AGENT_ID));  // R2

    AST_FWD_IS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (rsp_valid && rsp_code == 2'b00));  // R2

    AST_WSC_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_sb && req_kind == 2'b01 && !wsc_n && cfg_hs_en && cfg_int_arb)
        |=> (wsc_n || rsp_code == 2'b10));  // R3

    AST_WSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wsc_n && !(cpl_valid && cpl_sb)) |=> wsc_n);  // R4

    AST_WSC_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wsc_n && cpl_valid && cpl_sb) |=> !wsc_n);  // R4

    AST_RETRY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (wsc_n && req_valid && req_sb && req_kind == 2'b01)
        |=> (rsp_valid && !fwd_valid && rsp_code != 2'b00));  // R5

    AST_INACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!wsc_n && !(cfg_hs_en && cfg_int_arb)) |=> !wsc_n);  // R6

    AST_IO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind[1]) |=> (rsp_valid && rsp_code == 2'b10 && !fwd_valid));  // R8

    AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_orphan_cpl |=> err_orphan_cpl);  // R11
endmodule

bind iwo_handshake iwo_handshake_chk #(.AGENT_ID(AGENT_ID)) u_chk (.*);

// File: tb/iwo_handshake_tb.sv
`timescale 1ns/1ps
module iwo_handshake_tb;
    localparam int AW    = 32;
    localparam int CNT_W = 8;
    localparam logic [AW-1:0] ADDR_LOC  = 32'h0000_1000;
    localparam logic [AW-1:0] ADDR_PEER = 32'hC000_1000;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_hs_en, cfg_int_arb;
    logic             req_valid, req_sb, cpl_valid, cpl_sb;
    logic [1:0]       req_kind;
    logic [AW-1:0]    req_addr;
    logic             fwd_valid, fwd_write, fwd_tracked, rsp_valid, wsc_n, err_orphan_cpl;
    logic [AW-1:0]    fwd_addr;
    logic [3:0]       fwd_agent;
    logic [1:0]       rsp_code;
    logic [CNT_W-1:0] err_io_cnt, err_p2p_cnt;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    iwo_handshake u_dut (
        .clk(clk), .rst(rst), .cfg_hs_en(cfg_hs_en), .cfg_int_arb(cfg_int_arb),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_sb(req_sb),
        .cpl_valid(cpl_valid), .cpl_sb(cpl_sb),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
        .fwd_agent(fwd_agent), .fwd_tracked(fwd_tracked),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .wsc_n(wsc_n),
        .err_orphan_cpl(err_orphan_cpl), .err_io_cnt(err_io_cnt), .err_p2p_cnt(err_p2p_cnt)
    );

    // Vector: kind[12:11] peer[10] valid[9] sb[8] cpl[7] cplsb[6]
    //         exp_rv[5] exp_rsp[4:3] exp_fwd[2] exp_tracked[1] exp_wsc_n[0]
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        13'b00_0_0_0_0_0_0_00_0_0_0,  // idle
        13'b01_0_1_1_0_0_1_00_1_1_1,  // R3 sb write accepted
        13'b01_0_1_1_0_0_1_01_0_0_1,  // R5 retry
        13'b01_0_1_0_0_0_1_00_1_0_1,  // R10 other-master write
        13'b00_0_1_1_0_0_1_00_1_0_1,  // R10 sb read
        13'b11_0_1_1_0_0_1_10_0_0_1,  // R14 sb I/O write while pending
        13'b00_0_0_0_1_0_0_00_0_0_1,  // R4 untagged completion
        13'b00_0_0_0_1_1_0_00_0_0_0,  // R4 tagged completion releases
        13'b01_1_1_1_0_0_1_10_0_0_0,  // R9 peer write
        13'b01_0_1_1_0_0_1_00_1_1_1,  // R3 again
        13'b01_0_1_1_1_1_1_01_0_0_0,  // R5 retry with same-cycle completion
        13'b01_0_1_1_0_0_1_00_1_1_1,  // R3
        13'b00_0_0_0_1_1_0_00_0_0_0,  // R4
        13'b10_0_1_0_0_0_1_10_0_0_0   // R8 I/O read
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic [AW-1:0] a, input logic v,
                         input logic sb, input logic c, input logic csb);
        req_kind  = k;
        req_addr  = a;
        req_valid = v;
        req_sb    = sb;
        cpl_valid = c;
        cpl_sb    = csb;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cpl_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_hs_en = 1'b1; cfg_int_arb = 1'b1;
        req_valid = 1'b0; req_sb = 1'b0; cpl_valid = 1'b0; cpl_sb = 1'b0;
        req_kind = 2'b00; req_addr = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 wsc_n", wsc_n, 0);
        chk("R1 fwd_valid", fwd_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 orphan", err_orphan_cpl, 0);
        chk("R1 io_cnt", err_io_cnt, 0);

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            logic [AW-1:0] a;
            v = VEC[i];
            a = v[10] ? ADDR_PEER : ADDR_LOC;
            drive(v[12:11], a, v[9], v[8], v[7], v[6]);
            chk("R2 rsp_valid", rsp_valid, v[5]);
            if (v[5]) chk("R2 rsp_code", rsp_code, v[4:3]);
            chk("R5 fwd_valid", fwd_valid, v[2]);
            chk("R3 fwd_tracked", fwd_tracked, v[1]);
            chk("R4 wsc_n", wsc_n, v[0]);
            if (v[2]) begin
                chk("R2 agent", fwd_agent, 4'b1001);
                chk("R2 addr", fwd_addr, a);
                chk("R2 write", fwd_write, v[12:11] == 2'b01);
            end
        end
        chk("R8 io count", err_io_cnt, 2);
        chk("R9 p2p count", err_p2p_cnt, 1);

        // R6 external arbiter mode
        cfg_int_arb = 1'b0;
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R6 accept", rsp_code, 2'b00);
        chk("R6 wsc_n", wsc_n, 0);
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R6 second fwd", fwd_valid, 1);
        chk("R6 second wsc_n", wsc_n, 0);
        cfg_int_arb = 1'b1;

        // R7 handshake disabled
        cfg_hs_en = 1'b0;
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R7 accept", rsp_code, 2'b00);
        chk("R7 fwd", fwd_valid, 1);
        chk("R7 wsc_n", wsc_n, 0);
        cfg_hs_en = 1'b1;

        // R11 orphan completion
        drive(2'b00, ADDR_LOC, 0, 0, 1, 1);
        chk("R11 wsc_n", wsc_n, 0);
        chk("R11 flag", err_orphan_cpl, 1);
        drive(2'b00, ADDR_LOC, 0, 0, 0, 0);
        chk("R11 sticky", err_orphan_cpl, 1);

        // R12 config change while pending
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R12 pending", wsc_n, 1);
        cfg_hs_en = 1'b0;
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R12 still retry", rsp_code, 2'b01);
        chk("R12 wsc held", wsc_n, 1);
        drive(2'b00, ADDR_LOC, 0, 0, 1, 1);
        chk("R12 release", wsc_n, 0);
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        chk("R12 new setting accept", rsp_code, 2'b00);
        chk("R12 new setting wsc", wsc_n, 0);
        cfg_hs_en = 1'b1;

        // R13 saturation
        for (int j = 0; j < 300; j++) drive(2'b11, ADDR_LOC, 1, 0, 0, 0);
        chk("R13 io saturate", err_io_cnt, 8'hFF);
        for (int j = 0; j < 300; j++) drive(2'b00, ADDR_PEER, 1, 0, 0, 0);
        chk("R13 p2p saturate", err_p2p_cnt, 8'hFF);

        // R1 reset mid-run
        drive(2'b01, ADDR_LOC, 1, 1, 0, 0);
        do_reset();
        chk("R1 wsc after reset", wsc_n, 0);
        chk("R1 orphan after reset", err_orphan_cpl, 0);
        chk("R1 p2p after reset", err_p2p_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule